// File: doc/BRIEF.md
# SD Card Data Word Buffer

This block sits between a memory-mapped register port and the serial data-line engine of an SD card host. It holds up to 16 words of 32 bits. In card-read mode the engine pushes words that it has received from the card, and software drains them by reading the data port. In card-write mode software fills the buffer through writes to the same data port, and the engine pulls the words out to send them.

A debug register shows the current fill level and holds two programmable thresholds. The block combines each threshold with the block-size and block-count registers to produce one pacing request. Overflow and underflow on either side are recorded in a sticky error bit of a write-one-to-clear status register. The same register also flags the end of each block and the end of the whole transfer.

Register offsets: status 0x20, debug 0x34, block size 0x3C, data port 0x40, block count 0x50. The `xferWrite` input selects the direction: 0 is card-read and 1 is card-write.

Top module: `sd_word_fifo`

## Requirements
- R1: After reset the fill level is 0, the status register reads 0, the debug register reads 0x00010800 (both thresholds 4), the block size reads 512 and the block count reads 0.
- R2: Words leave the buffer in the order they entered, and up to 16 words can be held. The leaving word is seen combinationally on the data-port read (card-read mode) or on `engPopData` (card-write mode).
- R3: Status bit 0 and `haveData` are 1 exactly when `xferWrite` is 0 and the fill level is at least 1.
- R4: Debug register layout: bits [8:4] show the fill level (read-only), bits [13:9] hold the write threshold and bits [18:14] hold the read threshold. Both thresholds are writable. All other bits read 0.
- R5: A pop from an empty buffer returns 0 and sets status bit 3. A push into a full buffer drops the word and sets status bit 3. The full or empty state is the one at the start of the cycle.
- R6: Writing a 1 to status bit 3, 9 or 10 clears that bit. Writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R7: `engPushReady` is 1 exactly when `xferWrite` is 0 and the fill level is below 16.
- R8: In card-write mode, `paceReq` is 1 when the fill level is nonzero and either it exceeds the write threshold or it is at least the number of words still to leave in the current block.
- R9: In card-read mode, `paceReq` is 1 when the fill level is nonzero and either it is at least the read threshold or it is at least the number of words still to leave in the current block.
- R10: Status bit 9 is set when the last word of a block leaves the buffer. A block holds block-size/4 words, with a minimum of 1, and the block size is clamped to 512 on write.
- R11: Each completed block decrements a remaining-block count loaded from the block-count register. Status bit 10 is set when that count goes from 1 to 0. A write to the block-size or block-count register restarts the word count of the current block.
- R12: Accesses on the inactive side have no effect. A data-port write in card-read mode and an engine push in card-write mode are ignored. A data-port read in card-write mode returns 0 and neither pops nor flags an error.
- R13: A push and a pop in the same cycle on a partly filled buffer both take effect, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferWrite | input | 1 | 0 = card-read mode, 1 = card-write mode |
| regAddr | input | 8 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on the data port) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| engPush | input | 1 | Engine push strobe (card-read mode) |
| engPushData | input | 32 | Word from the engine |
| engPushReady | output | 1 | Engine may push |
| engPop | input | 1 | Engine pop strobe (card-write mode) |
| engPopData | output | 32 | Word to the engine |
| paceReq | output | 1 | Threshold or end-of-block pacing request |
| haveData | output | 1 | Words available to software |
| fillLevel | output | 5 | Current fill level |

## Verification
The bench sweeps every threshold value from 0 to 16 against every fill level from 0 to 16 in both modes. A design that swapped the strict and non-strict comparisons, or used the wrong threshold for a mode, would raise `paceReq` one word early or late. Overflow and underflow are forced on both the software side and the engine side. A design that stored a word into a full buffer, or returned stale data from an empty one, would corrupt the data order or leave the error bit clear. The bench also runs short blocks, so the end-of-block request, the block-done bit and the transfer-done bit can be seen firing one word off. Wrong-side accesses and simultaneous push and pop are checked at the fill level.

// File: rtl/sdwf_pkg.sv
package sdwf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_strobe_t;

  localparam logic [7:0] ADDR_STATUS = 8'h20;
  localparam logic [7:0] ADDR_DEBUG  = 8'h34;
  localparam logic [7:0] ADDR_BSIZE  = 8'h3C;
  localparam logic [7:0] ADDR_DATA   = 8'h40;
  localparam logic [7:0] ADDR_BCOUNT = 8'h50;

  localparam int ST_HAVE = 0;
  localparam int ST_ERR  = 3;
  localparam int ST_BLK  = 9;
  localparam int ST_XFER = 10;
endpackage

// File: rtl/sdwf_datapath.sv
module sdwf_datapath
  import sdwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifo_strobe_t     strb,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] fill
);
  logic [WIDTH-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) slot[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strb.push, strb.pop})
        2'b10:   fill <= fill + LVL_W'(1);
        2'b01:   fill <= fill - LVL_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign headData = slot[rdPtr];

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fill <= LVL_W'(DEPTH));
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && !strb.pop |=> fill == LVL_W'($past(fill) + 1'b1));
  p_balanced_r13: assert property (@(posedge clk) disable iff (!rstN)
    strb.push && strb.pop |=> $stable(fill));
endmodule

// File: rtl/sdwf_ctrl.sv
module sdwf_ctrl
  import sdwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int MAX_BLOCK_BYTES = 512,
  parameter int BCNT_W = 16,
  parameter int THR_RESET = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int BSZ_W = $clog2(MAX_BLOCK_BYTES + 1),
  localparam int WCNT_W = BSZ_W - 2,
  localparam int FILL_LSB = 4,
  localparam int WTH_LSB = FILL_LSB + LVL_W,
  localparam int RTH_LSB = WTH_LSB + LVL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferWrite,
  input  logic [7:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic              engPush,
  input  logic [WIDTH-1:0]  engPushData,
  output logic              engPushReady,
  input  logic              engPop,
  output logic [WIDTH-1:0]  engPopData,
  output logic              paceReq,
  output logic              haveData,
  input  logic [LVL_W-1:0]  fill,
  input  logic [WIDTH-1:0]  headData,
  output fifo_strobe_t      strb,
  output logic [WIDTH-1:0]  pushData
);
  logic isData, isStatus, isDebug, isBsize, isBcount;
  logic pushTry, popTry, full, empty, faultNow;
  logic errBit, blkDone, xferDone;
  logic [LVL_W-1:0] wThr, rThr;
  logic [BSZ_W-1:0] bSize;
  logic [BCNT_W-1:0] bCount, blkLeft;
  logic [WCNT_W-1:0] wordCnt, blockWords, wordsLeft;
  logic [WIDTH-1:0] popData;
  logic finalIn, levelHit;

  assign isData   = regAddr == ADDR_DATA;
  assign isStatus = regAddr == ADDR_STATUS;
  assign isDebug  = regAddr == ADDR_DEBUG;
  assign isBsize  = regAddr == ADDR_BSIZE;
  assign isBcount = regAddr == ADDR_BCOUNT;

  assign full  = fill == LVL_W'(DEPTH);
  assign empty = fill == '0;

  assign pushTry = xferWrite ? (regWr && isData) : engPush;
  assign popTry  = xferWrite ? engPop : (regRd && isData);

  assign strb.push = pushTry && !full;
  assign strb.pop  = popTry && !empty;
  assign pushData  = xferWrite ? regWdata : engPushData;
  assign faultNow  = (pushTry && full) || (popTry && empty);

  assign popData    = empty ? '0 : headData;
  assign engPopData = xferWrite ? popData : '0;

  assign engPushReady = !xferWrite && !full;
  assign haveData     = !xferWrite && !empty;

  assign blockWords = (bSize[BSZ_W-1:2] == '0) ? WCNT_W'(1) : bSize[BSZ_W-1:2];
  assign wordsLeft  = blockWords - wordCnt;
  assign finalIn    = 32'(fill) >= 32'(wordsLeft);
  assign levelHit   = xferWrite ? (fill > wThr) : (fill >= rThr);
  assign paceReq    = !empty && (finalIn || levelHit);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_DATA:   regRdata = xferWrite ? '0 : popData;
      ADDR_STATUS: begin
        regRdata[ST_HAVE] = haveData;
        regRdata[ST_ERR]  = errBit;
        regRdata[ST_BLK]  = blkDone;
        regRdata[ST_XFER] = xferDone;
      end
      ADDR_DEBUG: begin
        regRdata[FILL_LSB +: LVL_W] = fill;
        regRdata[WTH_LSB +: LVL_W]  = wThr;
        regRdata[RTH_LSB +: LVL_W]  = rThr;
      end
      ADDR_BSIZE:  regRdata = WIDTH'(bSize);
      ADDR_BCOUNT: regRdata = WIDTH'(bCount);
      default:     regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errBit   <= 1'b0;
      blkDone  <= 1'b0;
      xferDone <= 1'b0;
      wThr     <= LVL_W'(THR_RESET);
      rThr     <= LVL_W'(THR_RESET);
      bSize    <= BSZ_W'(MAX_BLOCK_BYTES);
      bCount   <= '0;
      blkLeft  <= '0;
      wordCnt  <= '0;
    end else begin
      if (regWr && isStatus) begin
        if (regWdata[ST_ERR])  errBit   <= 1'b0;
        if (regWdata[ST_BLK])  blkDone  <= 1'b0;
        if (regWdata[ST_XFER]) xferDone <= 1'b0;
      end
      if (regWr && isDebug) begin
        wThr <= regWdata[WTH_LSB +: LVL_W];
        rThr <= regWdata[RTH_LSB +: LVL_W];
      end
      if (faultNow) errBit <= 1'b1;

      if (regWr && isBsize) begin
        if (regWdata > WIDTH'(MAX_BLOCK_BYTES)) bSize <= BSZ_W'(MAX_BLOCK_BYTES);
        else bSize <= regWdata[BSZ_W-1:0];
        wordCnt <= '0;
      end else if (regWr && isBcount) begin
        bCount  <= regWdata[BCNT_W-1:0];
        blkLeft <= regWdata[BCNT_W-1:0];
        wordCnt <= '0;
      end else if (strb.pop) begin
        if (wordCnt + WCNT_W'(1) == blockWords) begin
          wordCnt <= '0;
          blkDone <= 1'b1;
          if (blkLeft != '0) begin
            blkLeft <= blkLeft - BCNT_W'(1);
            if (blkLeft == BCNT_W'(1)) xferDone <= 1'b1;
          end
        end else begin
          wordCnt <= wordCnt + WCNT_W'(1);
        end
      end
    end
  end

  p_pop_empty_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    popTry && (fill == '0) |=> errBit);
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    pushTry && (fill == LVL_W'(DEPTH)) && !popTry |=> fill == LVL_W'(DEPTH) && errBit);
  p_err_w1c_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWr && isStatus && regWdata[ST_ERR] && !faultNow |=> !errBit);
  p_engine_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    engPush && engPushReady && !(regRd && isData) |=> fill == LVL_W'($past(fill) + 1'b1));
  p_blk_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blkDone) |-> $past(strb.pop));
  p_wrong_side_r12: assert property (@(posedge clk) disable iff (!rstN)
    xferWrite && regRd && isData && !regWr && !engPop |=> $stable(fill) && $stable(errBit));
endmodule

// File: rtl/sd_word_fifo.sv
module sd_word_fifo
  import sdwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int MAX_BLOCK_BYTES = 512,
  parameter int BCNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferWrite,
  input  logic [7:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  input  logic             engPush,
  input  logic [WIDTH-1:0] engPushData,
  output logic             engPushReady,
  input  logic             engPop,
  output logic [WIDTH-1:0] engPopData,
  output logic             paceReq,
  output logic             haveData,
  output logic [LVL_W-1:0] fillLevel
);
  fifo_strobe_t     strb;
  logic [WIDTH-1:0] pushData, headData;

  sdwf_ctrl #(
    .DEPTH(DEPTH), .WIDTH(WIDTH),
    .MAX_BLOCK_BYTES(MAX_BLOCK_BYTES), .BCNT_W(BCNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .xferWrite(xferWrite),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .engPush(engPush), .engPushData(engPushData), .engPushReady(engPushReady),
    .engPop(engPop), .engPopData(engPopData),
    .paceReq(paceReq), .haveData(haveData),
    .fill(fillLevel), .headData(headData),
    .strb(strb), .pushData(pushData)
  );

  sdwf_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pushData(pushData), .headData(headData), .fill(fillLevel)
  );
endmodule

// File: tb/sim_sd_word_fifo.sv
module sim_sd_word_fifo;
  localparam logic [7:0] A_ST = 8'h20, A_DBG = 8'h34, A_BSZ = 8'h3C,
                         A_DAT = 8'h40, A_BCNT = 8'h50;

  logic clk = 1'b0, rstN = 1'b0, xferWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0, engPush = 1'b0, engPop = 1'b0;
  logic [31:0] regWdata = '0, engPushData = '0;
  logic [31:0] regRdata, engPopData;
  logic engPushReady, paceReq, haveData;
  logic [4:0] fillLevel;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  logic [31:0] mq[$];
  bit mErr, mBlk, mXfer, wm;
  int mWc, mBw, mBl, mWt, mRt, mBs;

  always #4 clk = ~clk;

  sd_word_fifo u0 (
    .clk(clk), .rstN(rstN), .xferWrite(xferWrite),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .engPush(engPush), .engPushData(engPushData), .engPushReady(engPushReady),
    .engPop(engPop), .engPopData(engPopData),
    .paceReq(paceReq), .haveData(haveData), .fillLevel(fillLevel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rw, input bit rr, input logic [7:0] a,
                     input logic [31:0] wd, input bit ep, input logic [31:0] epd,
                     input bit eo, output logic [31:0] rdv);
    logic [31:0] eov, pv;
    int f0;
    bit pushT, popT;
    @(negedge clk);
    regWr = rw; regRd = rr; regAddr = a; regWdata = wd;
    engPush = ep; engPushData = epd; engPop = eo;
    #1;
    rdv = regRdata;
    eov = engPopData;
    f0 = mq.size();
    pushT = wm ? (rw && a == A_DAT) : ep;
    popT  = wm ? eo : (rr && a == A_DAT);
    if (popT) begin
      pv = (f0 > 0) ? mq[0] : 32'h0;
      chk((f0 > 0) ? "R2 pop data" : "R5 empty pop data", wm ? eov : rdv, pv);
    end
    if (wm && rr && a == A_DAT) chk("R12 inactive read", rdv, 32'h0);
    @(posedge clk);
    #1;
    regWr = 0; regRd = 0; engPush = 0; engPop = 0;
    if (rw && a == A_ST) begin
      if (wd[3]) mErr = 0;
      if (wd[9]) mBlk = 0;
      if (wd[10]) mXfer = 0;
    end
    if (rw && a == A_DBG) begin mWt = int'(wd[13:9]); mRt = int'(wd[18:14]); end
    if (rw && a == A_BSZ) begin
      mBs = (wd > 512) ? 512 : int'(wd[9:0]);
      mBw = ((mBs >> 2) == 0) ? 1 : (mBs >> 2);
      mWc = 0;
    end
    if (rw && a == A_BCNT) begin mBl = int'(wd[15:0]); mWc = 0; end
    if (popT) begin
      if (f0 == 0) mErr = 1;
      else begin
        void'(mq.pop_front());
        mWc++;
        if (mWc == mBw) begin
          mWc = 0; mBlk = 1;
          if (mBl != 0) begin
            if (mBl == 1) mXfer = 1;
            mBl--;
          end
        end
      end
    end
    if (pushT) begin
      if (f0 >= 16) mErr = 1;
      else mq.push_back(wm ? wd : epd);
    end
  endtask

  task automatic swW(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x;
    cyc(1, 0, a, d, 0, 0, 0, x);
  endtask
  task automatic swR(input logic [7:0] a, output logic [31:0] d);
    cyc(0, 1, a, 0, 0, 0, 0, d);
  endtask
  task automatic ePush(input logic [31:0] d);
    logic [31:0] x;
    cyc(0, 0, 8'h00, 0, 1, d, 0, x);
  endtask
  task automatic ePop();
    logic [31:0] x;
    cyc(0, 0, 8'h00, 0, 0, 0, 1, x);
  endtask
  task automatic setMode(input bit m);
    @(negedge clk);
    xferWrite = m; wm = m;
  endtask

  task automatic checkAll(input string ctx);
    logic [31:0] r, expSt, expDbg;
    int f;
    bit expPace;
    f = mq.size();
    expSt = (32'(mXfer) << 10) | (32'(mBlk) << 9) | (32'(mErr) << 3) | 32'(!wm && f > 0);
    swR(A_ST, r);
    chk({"R3 R5 R10 R11 status ", ctx}, r, expSt);
    chk({"R3 haveData ", ctx}, 32'(haveData), 32'(!wm && f > 0));
    chk({"R4 fillLevel ", ctx}, 32'(fillLevel), 32'(f));
    chk({"R7 engPushReady ", ctx}, 32'(engPushReady), 32'(!wm && f < 16));
    expPace = (f > 0) && ((wm ? (f > mWt) : (f >= mRt)) || (f >= mBw - mWc));
    chk({wm ? "R8 paceReq " : "R9 paceReq ", ctx}, 32'(paceReq), 32'(expPace));
    expDbg = (32'(f) << 4) | (32'(mWt) << 9) | (32'(mRt) << 14);
    swR(A_DBG, r);
    chk({"R4 debug ", ctx}, r, expDbg);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'(i << 20);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, x;
    mErr = 0; mBlk = 0; mXfer = 0; wm = 0;
    mWc = 0; mBw = 128; mBl = 0; mWt = 4; mRt = 4; mBs = 512;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    swR(A_ST, r);   chk("R1 status", r, 32'h0);
    swR(A_DBG, r);  chk("R1 debug", r, 32'h00010800);
    swR(A_BSZ, r);  chk("R1 block size", r, 32'd512);
    swR(A_BCNT, r); chk("R1 block count", r, 32'd0);
    chk("R1 fill", 32'(fillLevel), 32'd0);
    checkAll("R1 reset");

    // Card-read mode: two 16-word blocks
    swW(A_BSZ, 32'd64);
    swW(A_BCNT, 32'd2);
    for (int i = 0; i < 16; i++) begin ePush(pat(i)); checkAll("rd fill up"); end
    ePush(32'hDEADBEEF);
    checkAll("R5 overflow engine");
    swW(A_ST, 32'h0);
    checkAll("R6 write zero keeps");
    swW(A_ST, 32'h8);
    checkAll("R6 write one clears");
    for (int i = 0; i < 16; i++) begin swR(A_DAT, r); checkAll("R2 R10 rd drain"); end
    swR(A_DAT, r);
    checkAll("R5 underflow software");
    swW(A_ST, 32'h608);
    for (int i = 0; i < 16; i++) ePush(pat(100 + i));
    for (int i = 0; i < 16; i++) begin swR(A_DAT, r); checkAll("R11 second block"); end
    swW(A_ST, 32'h608);
    checkAll("R6 clear all");

    // R13 simultaneous push and pop
    for (int i = 0; i < 5; i++) ePush(pat(200 + i));
    cyc(0, 1, A_DAT, 0, 1, pat(205), 0, r);
    checkAll("R13 read mode");
    // R12 data-port write in card-read mode ignored
    swW(A_DAT, 32'h12345678);
    checkAll("R12 write in read mode");
    for (int i = 0; i < 5; i++) swR(A_DAT, r);

    // R4 debug writes: only threshold fields stick
    swW(A_DBG, 32'hFFFFFFFF);
    checkAll("R4 all ones");
    swW(A_BSZ, 32'd4000);
    swR(A_BSZ, r); chk("R10 size clamp", r, 32'd512);

    // R9 sweep: read threshold vs fill
    swW(A_BCNT, 32'd0);
    for (int f = 0; f <= 16; f++) begin
      for (int t = 0; t <= 17; t++) begin
        swW(A_DBG, (32'(t) << 14) | (32'd4 << 9));
        checkAll("R9 sweep");
      end
      if (f < 16) ePush(pat(300 + f));
    end
    for (int i = 0; i < 16; i++) swR(A_DAT, r);

    // R9 final words of a short block
    swW(A_BSZ, 32'd32);
    swW(A_BCNT, 32'd1);
    swW(A_DBG, (32'd31 << 14) | (32'd31 << 9));
    for (int i = 0; i < 10; i++) begin ePush(pat(400 + i)); checkAll("R9 final words"); end
    for (int i = 0; i < 10; i++) begin swR(A_DAT, r); checkAll("R10 R11 short block"); end

    // Card-write mode
    setMode(1);
    swW(A_ST, 32'h608);
    swW(A_BSZ, 32'd64);
    swW(A_BCNT, 32'd1);
    for (int f = 0; f <= 16; f++) begin
      for (int t = 0; t <= 17; t++) begin
        swW(A_DBG, (32'd4 << 14) | (32'(t) << 9));
        checkAll("R8 sweep");
      end
      if (f < 16) swW(A_DAT, pat(500 + f));
    end
    swW(A_DAT, 32'hBAD0BAD0);
    checkAll("R5 overflow software");
    swR(A_DAT, r);
    checkAll("R12 read in write mode");
    ePush(32'hCAFEF00D);
    checkAll("R12 engine push in write mode");
    for (int i = 0; i < 16; i++) begin ePop(); checkAll("R2 R10 R11 engine drain"); end
    ePop();
    checkAll("R5 underflow engine");
    swW(A_ST, 32'h608);
    for (int i = 0; i < 4; i++) swW(A_DAT, pat(600 + i));
    cyc(1, 0, A_DAT, pat(604), 0, 0, 1, x);
    checkAll("R13 write mode");
    swW(A_BSZ, 32'd16);
    for (int i = 0; i < 4; i++) begin ePop(); checkAll("R8 short block drain"); end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule